// File: doc/BRIEF.md
# Prioritized Reset Request Sequencer

This block collects reset requests from four classes of source and turns them into one ordered reset sequence for a group of downstream modules. The classes are cold (a set of level-held inputs), watchdog, warm, and three software-initiated kinds (CPU warm, power-on style, L2). Only one reset runs at a time. Each run goes through four phases. First a handshake phase raises a request-to-modules line and waits for every acknowledge input. Then an assert phase holds every module reset for a parameterised number of cycles. Then a release phase drops the module resets one per cycle in index order. Last, the block returns to idle.

The run is committed once the handshake has finished, that is on entry to the assert phase. Whether a request arriving mid-run preempts the reset, waits behind it, or is discarded depends on the class pair and on that commit point. At most one request waits in a single slot, which keeps the highest-priority candidate. A one-hot output shows the class now running.

All inputs are synchronous to `clk`. The non-cold requests are single-cycle strobes. Cold requests are levels.

Top module: `reset_sequencer`

## Requirements
- R1: While `rstN` is low and just after it rises, `modReq` is 0, `modRst` is all zeros and `activeClass` is 0.
- R2: The `activeClass` bits are bit0 cold, bit1 watchdog, bit2 warm, bit3 software CPU, bit4 software power-on, bit5 software L2, and are all zero when idle. A request accepted from idle gives `modReq`=1 and the class bit from the next cycle. `modReq` stays 1 until all `ackIn` bits are 1. After that, every `modRst` bit is 1 for ASSERT_CYCLES cycles plus one release-decision cycle. Then one bit per cycle drops, lowest index first, and the block is idle in the cycle in which the last bit drops.
- R3: Requests arriving together in idle start the highest class only, and the others are discarded. Priority is cold > watchdog > warm > software, and among software requests the lower bit index wins.
- R4: During a cold run, all module resets stay asserted while any `coldReq` bit is 1. The release starts in the cycle after the last one drops, once the assert count has run out.
- R5: A cold request during the release phase of a cold run sets all `modRst` bits back to 1 and restarts the assert phase.
- R6: During an uncommitted warm run, a watchdog or cold request replaces the warm run at once. The handshake continues for the new class.
- R7: During a committed warm run, a watchdog or cold request is held. The warm run completes and the held request runs next.
- R8: During a warm run, any software request is discarded, committed or not.
- R9: During a watchdog run, warm and watchdog requests are discarded. A cold request preempts an uncommitted watchdog run and is held behind a committed one.
- R10: During a software run, a warm request is held until the software run completes. A watchdog or cold request aborts the run even when it is committed: the block returns to the handshake for the new class and the module resets keep their current values.
- R11: During a software run, another software request is discarded because all software kinds share one priority.
- R12: Only one request is held. When a second one must be held, the higher-priority of the two is kept and the other is lost.
- R13: A held request starts its handshake one cycle after the block has returned to idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset of the sequencer |
| coldReq | input | NUM_COLD | Level cold reset requests |
| wdogReq | input | 1 | Watchdog reset strobe |
| warmReq | input | 1 | Warm reset strobe |
| swReq | input | 3 | Software reset strobes: bit0 CPU, bit1 power-on, bit2 L2 |
| ackIn | input | NUM_ACK | Acknowledges from the modules for the handshake |
| modReq | output | 1 | Request-to-modules, high during the handshake |
| modRst | output | NUM_MOD | Module reset outputs, active high |
| activeClass | output | 6 | One-hot class of the running reset |

## Verification
The bench builds the block with ASSERT_CYCLES=3, NUM_MOD=3, NUM_COLD=2 and NUM_ACK=2. The short assert window and three-step release leave room to land watchdog and cold strobes inside the committed window of a warm, watchdog or software run. Two strobes can also be placed there back to back, which exercises the single holding slot. Two cold inputs show that the cold hold lasts until the last input drops. Two acknowledges let a partial acknowledge be seen to stall the handshake.

// File: rtl/reset_seq_pkg.sv
package reset_seq_pkg;

  localparam int NUM_CLASS = 6;

  typedef logic [NUM_CLASS-1:0] classVec_t;

  localparam classVec_t CLS_COLD = 6'b000001;
  localparam classVec_t CLS_WDOG = 6'b000010;
  localparam classVec_t CLS_WARM = 6'b000100;
  localparam classVec_t CLS_SW   = 6'b111000;

  typedef enum logic [1:0] {
    ST_IDLE     = 2'd0,
    ST_HSHK     = 2'd1,
    ST_ASSERT   = 2'd2,
    ST_DEASSERT = 2'd3
  } seqState_t;

  // strobes from control to datapath
  typedef struct packed {
    logic setAll;
    logic decCnt;
    logic relStep;
  } dpStrobe_t;

  // keep only the highest-priority (lowest index) set bit
  function automatic classVec_t lowestBit(input classVec_t v);
    return v & (~v + classVec_t'(1));
  endfunction

endpackage

// File: rtl/reset_seq_dp.sv
module reset_seq_dp
  import reset_seq_pkg::*;
#(
  parameter int NUM_MOD       = 4,
  parameter int ASSERT_CYCLES = 8
) (
  input  logic               clk,
  input  logic               rstN,
  input  dpStrobe_t          stb,
  output logic               cntZero,
  output logic               lastRel,
  output logic [NUM_MOD-1:0] modRst
);

  localparam int CNT_W = (ASSERT_CYCLES > 1) ? $clog2(ASSERT_CYCLES + 1) : 1;
  localparam int IDX_W = (NUM_MOD > 1) ? $clog2(NUM_MOD) : 1;
  localparam logic [CNT_W-1:0] CNT_LOAD = CNT_W'(ASSERT_CYCLES - 1);
  localparam logic [IDX_W-1:0] IDX_LAST = IDX_W'(NUM_MOD - 1);

  logic [CNT_W-1:0] holdCnt;
  logic [IDX_W-1:0] relIdx;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      holdCnt <= '0;
    end else if (stb.setAll) begin
      holdCnt <= CNT_LOAD;
    end else if (stb.decCnt && holdCnt != '0) begin
      holdCnt <= holdCnt - CNT_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      relIdx <= '0;
    end else if (stb.setAll) begin
      relIdx <= '0;
    end else if (stb.relStep && relIdx != IDX_LAST) begin
      relIdx <= relIdx + IDX_W'(1);
    end
  end

  assign cntZero = (holdCnt == '0);
  assign lastRel = (relIdx == IDX_LAST);

  // one flop per module reset, released in index order
  for (genvar i = 0; i < NUM_MOD; i++) begin : g_modRst
    logic bitQ;
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        bitQ <= 1'b0;
      end else if (stb.setAll) begin
        bitQ <= 1'b1;
      end else if (stb.relStep && relIdx == IDX_W'(i)) begin
        bitQ <= 1'b0;
      end
    end
    assign modRst[i] = bitQ;
  end

  AST_REL_ONE_BIT: assert property (@(posedge clk) disable iff (!rstN)
    stb.relStep |=> ($countones(modRst) == $countones($past(modRst)) - 1)); // R2

endmodule

// File: rtl/reset_seq_ctrl.sv
module reset_seq_ctrl
  import reset_seq_pkg::*;
#(
  parameter int NUM_COLD = 2,
  parameter int NUM_ACK  = 2
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic [NUM_COLD-1:0] coldReq,
  input  logic                wdogReq,
  input  logic                warmReq,
  input  logic [2:0]          swReq,
  input  logic [NUM_ACK-1:0]  ackIn,
  input  logic                cntZero,
  input  logic                lastRel,
  output dpStrobe_t           stb,
  output logic                modReq,
  output classVec_t           activeClass
);

  seqState_t state, stateNext;
  classVec_t curCls, clsNext;
  classVec_t heldCls, heldNext;

  classVec_t arrivals;
  classVec_t preemptSet;
  classVec_t queueSet;
  classVec_t preemptPick;
  classVec_t idleCand;
  logic      committed;
  logic      coldHeld;
  logic      doPreempt;

  assign arrivals  = {swReq, warmReq, wdogReq, |coldReq};
  assign committed = (state == ST_ASSERT) || (state == ST_DEASSERT);
  assign coldHeld  = (curCls == CLS_COLD) && (|coldReq);

  // class-pair resolution: which arrivals preempt, which are held
  always_comb begin
    preemptSet = '0;
    queueSet   = '0;
    if (curCls == CLS_WARM) begin
      if (committed) queueSet   = arrivals & (CLS_COLD | CLS_WDOG);
      else           preemptSet = arrivals & (CLS_COLD | CLS_WDOG);
    end else if (curCls == CLS_WDOG) begin
      if (committed) queueSet   = arrivals & CLS_COLD;
      else           preemptSet = arrivals & CLS_COLD;
    end else if ((curCls & CLS_SW) != '0) begin
      preemptSet = arrivals & (CLS_COLD | CLS_WDOG);
      queueSet   = arrivals & CLS_WARM;
    end
  end

  assign preemptPick = lowestBit(preemptSet);
  assign doPreempt   = (preemptSet != '0);
  assign idleCand    = arrivals | heldCls;

  always_comb begin
    stateNext = state;
    clsNext   = curCls;
    heldNext  = lowestBit(heldCls | queueSet | (preemptSet & ~preemptPick));
    stb       = '0;
    unique case (state)
      ST_IDLE: begin
        heldNext = '0;
        if (idleCand != '0) begin
          stateNext = ST_HSHK;
          clsNext   = lowestBit(idleCand);
        end
      end
      ST_HSHK: begin
        if (doPreempt) begin
          clsNext = preemptPick;
        end else if (&ackIn) begin
          stateNext  = ST_ASSERT;
          stb.setAll = 1'b1;
        end
      end
      ST_ASSERT: begin
        if (doPreempt) begin
          clsNext   = preemptPick;
          stateNext = ST_HSHK;
        end else if (cntZero && !coldHeld) begin
          stateNext = ST_DEASSERT;
        end else begin
          stb.decCnt = 1'b1;
        end
      end
      ST_DEASSERT: begin
        if (doPreempt) begin
          clsNext   = preemptPick;
          stateNext = ST_HSHK;
        end else if (coldHeld) begin
          stateNext  = ST_ASSERT;
          stb.setAll = 1'b1;
        end else begin
          stb.relStep = 1'b1;
          if (lastRel) stateNext = ST_IDLE;
        end
      end
      default: stateNext = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state   <= ST_IDLE;
      curCls  <= '0;
      heldCls <= '0;
    end else begin
      state   <= stateNext;
      curCls  <= clsNext;
      heldCls <= heldNext;
    end
  end

  assign modReq      = (state == ST_HSHK);
  assign activeClass = (state == ST_IDLE) ? '0 : curCls;

  AST_CLASS_ONEHOT: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(activeClass)); // R2
  AST_HSHK_WAIT: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_HSHK && !(&ackIn)) |=> (state != ST_ASSERT)); // R2
  AST_COLD_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_ASSERT && activeClass == CLS_COLD && |coldReq) |=> (state == ST_ASSERT)); // R4
  AST_COLD_REENTER: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_DEASSERT && activeClass == CLS_COLD && |coldReq) |=> (state == ST_ASSERT)); // R5
  AST_WARM_KEEP: assert property (@(posedge clk) disable iff (!rstN)
    (committed && activeClass == CLS_WARM) |=> (activeClass == CLS_WARM || activeClass == '0)); // R7
  AST_SW_ABORT: assert property (@(posedge clk) disable iff (!rstN)
    (committed && (activeClass & CLS_SW) != '0 && (arrivals & (CLS_COLD | CLS_WDOG)) != '0)
      |=> (state == ST_HSHK && (activeClass & (CLS_COLD | CLS_WDOG)) != '0)); // R10

endmodule

// File: rtl/reset_sequencer.sv
module reset_sequencer
  import reset_seq_pkg::*;
#(
  parameter int NUM_COLD      = 2,
  parameter int NUM_ACK       = 2,
  parameter int NUM_MOD       = 4,
  parameter int ASSERT_CYCLES = 8
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic [NUM_COLD-1:0] coldReq,
  input  logic                wdogReq,
  input  logic                warmReq,
  input  logic [2:0]          swReq,
  input  logic [NUM_ACK-1:0]  ackIn,
  output logic                modReq,
  output logic [NUM_MOD-1:0]  modRst,
  output logic [5:0]          activeClass
);

  dpStrobe_t stb;
  logic      cntZero;
  logic      lastRel;
  classVec_t clsVec;

  reset_seq_ctrl #(
    .NUM_COLD (NUM_COLD),
    .NUM_ACK  (NUM_ACK)
  ) u_ctrl (
    .clk         (clk),
    .rstN        (rstN),
    .coldReq     (coldReq),
    .wdogReq     (wdogReq),
    .warmReq     (warmReq),
    .swReq       (swReq),
    .ackIn       (ackIn),
    .cntZero     (cntZero),
    .lastRel     (lastRel),
    .stb         (stb),
    .modReq      (modReq),
    .activeClass (clsVec)
  );

  reset_seq_dp #(
    .NUM_MOD       (NUM_MOD),
    .ASSERT_CYCLES (ASSERT_CYCLES)
  ) u_dp (
    .clk     (clk),
    .rstN    (rstN),
    .stb     (stb),
    .cntZero (cntZero),
    .lastRel (lastRel),
    .modRst  (modRst)
  );

  assign activeClass = clsVec;

endmodule

// File: tb/sim_reset_sequencer.sv
module sim_reset_sequencer;

  localparam int CLK_PERIOD = 10;
  localparam int NC = 2;
  localparam int NA = 2;
  localparam int NM = 3;
  localparam int AC = 3;

  localparam logic [5:0] C_COLD = 6'b000001;
  localparam logic [5:0] C_WDOG = 6'b000010;
  localparam logic [5:0] C_WARM = 6'b000100;
  localparam logic [5:0] C_CPU  = 6'b001000;
  localparam logic [5:0] C_POR  = 6'b010000;
  localparam logic [5:0] C_L2   = 6'b100000;

  // {simultaneous requests, expected winning class}
  localparam int NVEC = 7;
  localparam logic [11:0] VEC [NVEC] = '{
    {6'b000110, 6'b000010},
    {6'b111000, 6'b001000},
    {6'b110100, 6'b000100},
    {6'b000011, 6'b000001},
    {6'b101000, 6'b001000},
    {6'b110000, 6'b010000},
    {6'b100010, 6'b000010}
  };

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic [NC-1:0] coldReq = '0;
  logic          wdogReq = 1'b0;
  logic          warmReq = 1'b0;
  logic [2:0]    swReq = '0;
  logic [NA-1:0] ackIn = '0;
  logic          modReq;
  logic [NM-1:0] modRst;
  logic [5:0]    activeClass;

  int total = 0;
  int bad = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  reset_sequencer #(
    .NUM_COLD (NC), .NUM_ACK (NA), .NUM_MOD (NM), .ASSERT_CYCLES (AC)
  ) u0 (
    .clk (clk), .rstN (rstN), .coldReq (coldReq), .wdogReq (wdogReq),
    .warmReq (warmReq), .swReq (swReq), .ackIn (ackIn),
    .modReq (modReq), .modRst (modRst), .activeClass (activeClass)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%0h exp=%0h t=%0t", req, act, exp, $time);
    end
  endtask

  // drive a one-cycle request set at a negedge, return at the next negedge
  task automatic pulse(input logic [5:0] v);
    coldReq = v[0] ? NC'(1) : '0;
    wdogReq = v[1];
    warmReq = v[2];
    swReq   = v[5:3];
    @(negedge clk);
    coldReq = '0;
    wdogReq = 1'b0;
    warmReq = 1'b0;
    swReq   = '0;
  endtask

  task automatic waitLeave(input logic [5:0] cls);
    ackIn = '1;
    for (int i = 0; i < 60 && activeClass == cls; i++) @(negedge clk);
    ackIn = '0;
  endtask

  task automatic finishAll();
    ackIn = '1;
    for (int i = 0; i < 80 && activeClass != '0; i++) @(negedge clk);
    ackIn = '0;
  endtask

  task automatic commitNow();
    ackIn = '1;
    @(negedge clk);
    ackIn = '0;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      bad++;
      $display("FAIL watchdog expired, all requirements act=hung exp=done");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    // R1 reset state
    repeat (3) @(negedge clk);
    chk("R1 modReq in reset", 32'(modReq), 0);
    chk("R1 modRst in reset", 32'(modRst), 0);
    rstN = 1'b1;
    @(negedge clk);
    chk("R1 class after reset", 32'(activeClass), 0);
    chk("R1 modRst after reset", 32'(modRst), 0);

    // R2 full sequence with a warm request
    pulse(C_WARM);
    chk("R2 class warm", 32'(activeClass), 32'(C_WARM));
    chk("R2 modReq up", 32'(modReq), 1);
    chk("R2 modRst low in handshake", 32'(modRst), 0);
    @(negedge clk);
    chk("R2 wait no ack", 32'(modReq), 1);
    ackIn = 2'b01;
    @(negedge clk);
    chk("R2 wait partial ack", 32'(modReq), 1);
    ackIn = 2'b11;
    @(negedge clk);
    ackIn = '0;
    chk("R2 all asserted", 32'(modRst), 32'(3'b111));
    chk("R2 modReq down", 32'(modReq), 0);
    repeat (3) @(negedge clk);
    chk("R2 still asserted", 32'(modRst), 32'(3'b111));
    @(negedge clk);
    chk("R2 release bit0", 32'(modRst), 32'(3'b110));
    @(negedge clk);
    chk("R2 release bit1", 32'(modRst), 32'(3'b100));
    @(negedge clk);
    chk("R2 release bit2", 32'(modRst), 0);
    chk("R2 idle", 32'(activeClass), 0);

    // R3 priority among simultaneous requests in idle
    for (int k = 0; k < NVEC; k++) begin
      pulse(VEC[k][11:6]);
      chk("R3 winner", 32'(activeClass), 32'(VEC[k][5:0]));
      finishAll();
      @(negedge clk);
      chk("R3 others discarded", 32'(activeClass), 0);
    end

    // R4 cold hold until every cold input drops
    coldReq = 2'b11;
    @(negedge clk);
    chk("R4 cold starts", 32'(activeClass), 32'(C_COLD));
    coldReq = 2'b10;
    commitNow();
    repeat (8) @(negedge clk);
    chk("R4 held by second input", 32'(modRst), 32'(3'b111));
    chk("R4 class cold", 32'(activeClass), 32'(C_COLD));
    coldReq = '0;
    @(negedge clk);
    chk("R4 release decision", 32'(modRst), 32'(3'b111));
    @(negedge clk);
    chk("R4 release begins", 32'(modRst), 32'(3'b110));
    finishAll();

    // R5 cold during cold release re-asserts
    pulse(C_COLD);
    ackIn = '1;
    for (int i = 0; i < 20 && modRst != 3'b110; i++) @(negedge clk);
    ackIn = '0;
    coldReq = 2'b01;
    @(negedge clk);
    coldReq = '0;
    chk("R5 re-asserted", 32'(modRst), 32'(3'b111));
    chk("R5 still cold", 32'(activeClass), 32'(C_COLD));
    finishAll();

    // R6 uncommitted warm replaced by cold
    pulse(C_WARM);
    pulse(C_COLD);
    chk("R6 replaced by cold", 32'(activeClass), 32'(C_COLD));
    chk("R6 handshake continues", 32'(modReq), 1);
    finishAll();
    @(negedge clk);
    chk("R6 warm not resumed", 32'(activeClass), 0);

    // R7 committed warm holds watchdog; R13 one idle cycle
    pulse(C_WARM);
    commitNow();
    pulse(C_WDOG);
    chk("R7 warm continues", 32'(activeClass), 32'(C_WARM));
    waitLeave(C_WARM);
    chk("R13 idle between", 32'(activeClass), 0);
    @(negedge clk);
    chk("R7 held watchdog runs", 32'(activeClass), 32'(C_WDOG));
    finishAll();

    // R8 software ignored during warm
    pulse(C_WARM);
    pulse(C_L2);
    chk("R8 warm continues", 32'(activeClass), 32'(C_WARM));
    finishAll();
    @(negedge clk);
    chk("R8 software dropped", 32'(activeClass), 0);

    // R9 watchdog: warm ignored, cold preempts uncommitted
    pulse(C_WDOG);
    pulse(C_WARM);
    chk("R9 warm ignored", 32'(activeClass), 32'(C_WDOG));
    pulse(C_COLD);
    chk("R9 cold preempts", 32'(activeClass), 32'(C_COLD));
    finishAll();
    @(negedge clk);
    chk("R9 nothing pending", 32'(activeClass), 0);
    // R9 committed watchdog holds cold
    pulse(C_WDOG);
    commitNow();
    pulse(C_COLD);
    chk("R9 committed continues", 32'(activeClass), 32'(C_WDOG));
    waitLeave(C_WDOG);
    chk("R9 idle between", 32'(activeClass), 0);
    @(negedge clk);
    chk("R9 held cold runs", 32'(activeClass), 32'(C_COLD));
    finishAll();

    // R10 committed software aborted by watchdog
    pulse(C_CPU);
    commitNow();
    chk("R10 software asserted", 32'(modRst), 32'(3'b111));
    pulse(C_WDOG);
    chk("R10 aborted to watchdog", 32'(activeClass), 32'(C_WDOG));
    chk("R10 back to handshake", 32'(modReq), 1);
    chk("R10 resets kept", 32'(modRst), 32'(3'b111));
    finishAll();
    // R10 warm waits for software
    pulse(C_CPU);
    pulse(C_WARM);
    chk("R10 software continues", 32'(activeClass), 32'(C_CPU));
    waitLeave(C_CPU);
    chk("R10 idle between", 32'(activeClass), 0);
    @(negedge clk);
    chk("R10 warm runs after", 32'(activeClass), 32'(C_WARM));
    finishAll();

    // R11 same-domain requests ignored
    pulse(C_CPU);
    pulse(C_POR);
    chk("R11 cpu continues", 32'(activeClass), 32'(C_CPU));
    finishAll();
    @(negedge clk);
    chk("R11 por dropped", 32'(activeClass), 0);
    pulse(C_WDOG);
    pulse(C_WDOG);
    finishAll();
    @(negedge clk);
    chk("R11 second watchdog dropped", 32'(activeClass), 0);

    // R12 single slot keeps the higher request
    pulse(C_WARM);
    commitNow();
    pulse(C_WDOG);
    pulse(C_COLD);
    chk("R12 warm continues", 32'(activeClass), 32'(C_WARM));
    waitLeave(C_WARM);
    @(negedge clk);
    chk("R12 cold kept", 32'(activeClass), 32'(C_COLD));
    finishAll();
    @(negedge clk);
    chk("R12 watchdog lost", 32'(activeClass), 0);

    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule